// File: doc/BRIEF.md
# Event Flag Queue Arbiter

This block gathers single-cycle event pulses from several independent sources into one ordered queue. Typical sources are a serial bus controller, a UART, and the frame and line syncs of a camera. Every source has its own sticky pending bit, so pulses from different sources never merge into one event.

A round-robin scanner looks at the pending bits that software has enabled. It writes the index of one pending source per cycle into a shared first-in first-out queue. A source's pending bit is cleared only in the cycle its event is actually written. If the queue is full, the event waits.

A consumer state machine reads the queue through a show-ahead read port: the head entry is visible whenever the empty indication is low, and each read removes one event. The enable mask is applied by AND gating. A masked source still records its pulse, but is not queued until its enable bit is set.

Top module: `evq_arbiter`

## Requirements
- R1: After reset, empty is 1 and no entry appears while no flag pulses. Pulses that arrive while reset is asserted are discarded.
- R2: An enabled source i pulsed so that it is sampled at rising edge k appears at the head of an otherwise empty queue after edge k+1, and not earlier. The entry value is i in bits [2:0], with all upper bits zero.
- R3: Each source has its own pending buffer. Simultaneous pulses on several enabled sources produce exactly one entry per pulsed source, and then the queue is empty.
- R4: Further pulses on a source whose event is still pending merge into that one event. Exactly one entry is produced.
- R5: Source i is queued only while src_enable[i] is 1. A masked pulse stays pending and is queued once after its bit is set. Other enabled sources are unaffected by the mask.
- R6: When several sources are pending, entries are written in increasing index order. The order starts at the source after the last one queued and wraps from 7 to 0. After reset the scan starts at source 0.
- R7: At most one entry is written and at most one is removed per cycle. Entries leave in the order they were written.
- R8: The queue holds 320 entries. When it is full, nothing is written and pending events stay pending. They are written as reads free space, so no event is lost or overwritten.
- R9: A read while the queue is empty has no effect. Later entries are returned correctly.
- R10: A pulse that arrives in the same cycle as its source's earlier event is queued is kept as a new event. A flag held high for n cycles therefore yields n entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flag_in | input | 8 | Single-cycle event pulses, one bit per source |
| src_enable | input | 8 | Per-source enable mask, 1 lets the source be queued |
| rd_en | input | 1 | Consumer read: removes the head entry when not empty |
| rd_data | output | 32 | Head entry: source index, zero-extended |
| empty | output | 1 | 1 when the queue holds no entry |

## Verification
A flag sampled at a rising edge sets its pending bit at that edge. It is written into the queue at the next edge, so the head entry and the low empty indication are due one full cycle after the sample edge. The bench checks that empty is still high at the falling edge between the two edges and low at the falling edge after the second one. All inputs change and all outputs are sampled on falling edges. Reads are issued one per cycle, and each head value is compared before the edge that removes it. When several sources are pulsed at once, the bench waits at least one cycle per pending source before it reads, so the round-robin order can be compared as a whole.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int index_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // base + step, wrapped into 0 .. n-1 (step assumed <= n).
  function automatic int wrap_add(input int base, input int step, input int n);
    int s;
    s = base + step;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/evq_capture.sv
module evq_capture #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_in,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic pend_q;
    logic pend_d;

    // A pulse arriving in the clearing cycle survives as a new event.
    always_comb begin
      pend_d = pend_q;
      if (clr[i])     pend_d = 1'b0;
      if (flag_in[i]) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    assign pend[i] = pend_q;
  end

endmodule

// File: rtl/evq_scanner.sv
module evq_scanner #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = evq_pkg::index_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] enable,
  input  logic               q_full,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [NUM_SRC-1:0] clr
);

  logic [NUM_SRC-1:0] eligible;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W-1:0]   last_d;
  logic [IDX_W-1:0]   pick;
  logic               found;

  assign eligible = pend & enable;

  // Round-robin search starting after the last served source.
  always_comb begin
    int j;
    found = 1'b0;
    pick  = '0;
    for (int off = 1; off <= NUM_SRC; off++) begin
      j = evq_pkg::wrap_add(int'(last_q), off, NUM_SRC);
      if (!found && eligible[j]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end

  always_comb begin
    wr_en  = found && !q_full;
    wr_idx = pick;
    clr    = '0;
    if (wr_en) clr[pick] = 1'b1;
    last_d = wr_en ? pick : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(NUM_SRC - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 320,
  localparam int PTR_W = evq_pkg::index_width(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             do_wr;
  logic             do_rd;

  assign empty = (level_q == '0);
  assign full  = (level_q == LVL_W'(DEPTH));
  assign level = level_q;
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];

endmodule

// File: rtl/evq_arbiter.sv
module evq_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int ENTRY_W = 32,
  parameter int DEPTH   = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_in,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               empty
);

  localparam int IDX_W = evq_pkg::index_width(NUM_SRC);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic               rst_int_n;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic               q_wr;
  logic [IDX_W-1:0]   q_idx;
  logic               q_full;
  logic [LVL_W-1:0]   q_level;

  evq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  evq_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .flag_in (flag_in),
    .clr     (clr),
    .pend    (pend)
  );

  evq_scanner #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pend   (pend),
    .enable (src_enable),
    .q_full (q_full),
    .wr_en  (q_wr),
    .wr_idx (q_idx),
    .clr    (clr)
  );

  evq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (q_wr),
    .wr_data (ENTRY_W'(q_idx)),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (empty),
    .full    (q_full),
    .level   (q_level)
  );

endmodule

// File: rtl/evq_checker.sv
module evq_checker #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 320,
  localparam int IDX_W  = evq_pkg::index_width(NUM_SRC),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] clr,
  input logic [NUM_SRC-1:0] enable,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic               full,
  input logic               empty,
  input logic [LVL_W-1:0]   level
);

  // R3: only a pending buffer is ever cleared
  p_clear_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr & ~pend) == '0);

  // R5: a masked source is never written
  p_masked_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> enable[wr_idx]);

  // R8: no write is offered to a full queue
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R8: a pending event not cleared stays pending
  p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

  // R8: the fill level never exceeds the depth
  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R9: an empty queue with no write stays empty whatever is read
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en) |=> empty);

  // R7: the fill level moves by at most one per cycle
  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1 ||
              level + 1'b1 == $past(level)));

endmodule

bind evq_arbiter evq_checker #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .pend   (pend),
  .clr    (clr),
  .enable (src_enable),
  .wr_en  (q_wr),
  .wr_idx (q_idx),
  .full   (q_full),
  .empty  (empty),
  .level  (q_level)
);

// File: tb/evq_arbiter_test.sv
module evq_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 7;
  localparam int WATCHDOG   = 20000;

  // {flags[43:36], count[35:32], expected order nibbles, first in [3:0]}
  localparam logic [43:0] VEC [NV] = '{
    {8'h01, 4'd1, 32'h0000_0000},
    {8'h81, 4'd2, 32'h0000_0007},
    {8'h16, 4'd3, 32'h0000_0421},
    {8'h29, 4'd3, 32'h0000_0305},
    {8'hFF, 4'd8, 32'h3210_7654},
    {8'h0C, 4'd2, 32'h0000_0032},
    {8'h50, 4'd2, 32'h0000_0064}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  flag_in;
  logic [7:0]  src_enable;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        empty;

  int checks = 0;
  int fails  = 0;

  evq_arbiter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_in    (flag_in),
    .src_enable (src_enable),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .empty      (empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] f, input int cycles);
    @(negedge clk);
    flag_in = f;
    repeat (cycles) @(negedge clk);
    flag_in = '0;
  endtask

  task automatic pop_expect(input logic [31:0] exp, input string tag);
    check(!empty && rd_data == exp, tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    check(empty == 1'b1, tag, {31'd0, empty}, 32'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [43:0] vec;
    int          got;
    int          bad;
    rst_n      = 1'b0;
    flag_in    = '0;
    src_enable = '1;
    rd_en      = 1'b0;

    // R1: pulses during reset are dropped
    repeat (2) @(negedge clk);
    flag_in = 8'h04;
    @(negedge clk);
    flag_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_empty("R1");
    repeat (4) @(negedge clk);
    expect_empty("R1");

    // Table: simultaneous pulses, round-robin order (R3, R6)
    for (int v = 0; v < NV; v++) begin
      vec = VEC[v];
      pulse(vec[43:36], 1);
      repeat (12) @(negedge clk);
      for (int k = 0; k < int'(vec[35:32]); k++)
        pop_expect({28'd0, vec[4*k +: 4]}, "R6");
      expect_empty("R3");
    end

    // R2: latency of a single pulse
    @(negedge clk);
    flag_in = 8'h20;
    @(negedge clk);
    flag_in = '0;
    expect_empty("R2");
    @(negedge clk);
    pop_expect(32'd5, "R2");
    expect_empty("R2");

    // R9: reads on an empty queue
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    expect_empty("R9");
    pulse(8'h04, 1);
    repeat (4) @(negedge clk);
    pop_expect(32'd2, "R9");
    expect_empty("R9");

    // R5 / R4: masking and merging
    src_enable = 8'hF7;
    pulse(8'h0A, 1);
    repeat (2) @(negedge clk);
    pulse(8'h08, 1);
    repeat (6) @(negedge clk);
    pop_expect(32'd1, "R5");
    expect_empty("R5");
    src_enable = 8'hFF;
    repeat (4) @(negedge clk);
    pop_expect(32'd3, "R4");
    expect_empty("R4");

    // R10: flag held two cycles gives two events
    pulse(8'h40, 2);
    repeat (5) @(negedge clk);
    pop_expect(32'd6, "R10");
    pop_expect(32'd6, "R10");
    expect_empty("R10");

    // R7: queue order follows write order, not index order
    pulse(8'h10, 1);
    repeat (3) @(negedge clk);
    pulse(8'h02, 1);
    repeat (4) @(negedge clk);
    pop_expect(32'd4, "R7");
    pop_expect(32'd1, "R7");
    expect_empty("R7");

    // R8: fill to 320, stall, then drain
    pulse(8'h01, 330);
    pulse(8'h20, 1);
    repeat (3) @(negedge clk);
    check(!empty, "R8", {31'd0, empty}, 32'd0);
    got = 0;
    bad = 0;
    for (int n = 0; n < 400; n++) begin
      if (empty) break;
      if (got < 320) begin
        if (rd_data != 32'd0) bad++;
      end else if (got == 320) begin
        if (rd_data != 32'd5) bad++;
      end else if (rd_data != 32'd0) bad++;
      got++;
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
    check(got == 322, "R8", got, 322);
    check(bad == 0, "R8", bad, 0);
    @(negedge clk);
    expect_empty("R8");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule